// File: doc/BRIEF.md
# Transmit Flow-Control Credit Gate

This block sits between an application's TLP source and a PCIe transaction core. It decides, each cycle, whether the TLP that the application is offering may go out without overrunning the receiver's advertised buffer space. For each of the three TLP classes (posted, non-posted, completion) it keeps a header-credit counter and a data-credit counter. The counters grow with every TLP the block grants and with every one-cycle consumption pulse that the core reports for messages it sends on its own behalf.

A request names a class and a payload length in bytes. The block converts the length into 16-byte data credits, adds one header credit, and compares the projected totals against the limits with modulo arithmetic, the way flow-control counters wrap. A type flagged as unlimited never blocks. Until the data link is up, every counter is held at zero and nothing is granted. A granted request is charged in the same cycle and reported one cycle later on an update record. A select input switches the credit view outputs between the running consumed totals and the limits.

Top module: `tx_credit_gate`

## Requirements
- R1: Class encoding on `req_class` and on the index of the packed limit and view arrays is 0 posted, 1 non-posted, 2 completion. A granted request adds one to that class's header counter and its data-credit need to that class's data counter at the next clock edge.
- R2: The data-credit need is the byte length divided by 16, rounded up: 0 bytes needs 0, 1 to 16 bytes need 1, 17 bytes need 2. A need of 0 is never blocked by data credits.
- R3: Bit positions of `core_used` and `unlimited` are 5 posted header, 4 posted data, 3 non-posted header, 2 non-posted data, 1 completion header, 0 completion data. Each set bit of `core_used` adds one to the matching counter at the next edge.
- R4: When a granted request and a core pulse hit the same counter in one cycle, both increments are applied in that cycle.
- R5: `grant` is high, combinationally, exactly when `link_up` and `req_valid` are high, the class is 0 to 2, and both checks pass for that class. The header check passes when (limit − (consumed + 1)) mod 256 ≤ 128. The data check passes when (limit − (consumed + need)) mod 4096 ≤ 2048. Class 3 is never granted.
- R6: A set `unlimited` bit makes the matching check pass whatever the limit and counter values.
- R7: While `link_up` is low, `grant` is low and all counters are zero one edge later. Requests and core pulses have no effect.
- R8: With `view_sel` high, `view_hdr`/`view_dat` show the consumed counters. With it low, they show the limit inputs.
- R9: One cycle after a grant, `upd_valid` is 1 and `upd_class`/`upd_dat` hold the class and data credits charged. Otherwise all three are 0.
- R10: Synchronous active-low reset clears all counters and the update record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Data link is up |
| lim_hdr | input | 3x8 | Header credit limit per class |
| lim_dat | input | 3x12 | Data credit limit per class |
| core_used | input | 6 | One-cycle consumption pulses from the core |
| unlimited | input | 6 | Per-type unlimited-credit flags |
| req_valid | input | 1 | A TLP is offered |
| req_class | input | 2 | Class of the offered TLP |
| req_len | input | 13 | Payload length in bytes |
| view_sel | input | 1 | 1: view consumed counters, 0: view limits |
| grant | output | 1 | Offered TLP may be sent this cycle |
| upd_valid | output | 1 | A charge was applied last cycle |
| upd_class | output | 2 | Class charged last cycle |
| upd_dat | output | 12 | Data credits charged last cycle |
| view_hdr | output | 3x8 | Header credit view per class |
| view_dat | output | 3x12 | Data credit view per class |

## Verification
A counter that drifts from the true consumed total first shows on `view_hdr`/`view_dat` with `view_sel` high, on the edge after the faulty increment. It reaches `grant` only when the error moves a projected total across the half-range boundary, which can take many requests. The bench therefore compares the consumed views on every cycle against its own totals, so a dropped pulse, a lost same-cycle increment or a wrong rounding is caught within one cycle. It then drives limits close to the counters and past the wrap point, so that a wrong comparison flips `grant` in the same cycle.

// File: rtl/tx_credit_pkg.sv
// Package: shared constants for the transmit credit gate.
// Assumes three TLP classes, each with one header and one data credit type.
package tx_credit_pkg;

    localparam int NUM_CLS = 3;

    typedef enum logic [1:0] {
        CLS_POST    = 2'd0,
        CLS_NONPOST = 2'd1,
        CLS_CPL     = 2'd2,
        CLS_NONE    = 2'd3
    } tlp_class_e;

    // Position of a class's header bit in the six-bit type vectors.
    function automatic int hdr_bit(input int cls);
        return 5 - 2 * cls;
    endfunction

    // Position of a class's data bit in the six-bit type vectors.
    function automatic int dat_bit(input int cls);
        return 4 - 2 * cls;
    endfunction

endpackage

// File: rtl/credit_need.sv
// Module: converts a payload byte count into data credits, rounded up.
// Assumes UNIT_BYTES is a power of two and the result fits in DAT_W bits.
module credit_need #(
    parameter int LEN_W      = 13,
    parameter int DAT_W      = 12,
    parameter int UNIT_BYTES = 16
) (
    input  logic [LEN_W-1:0] len,
    output logic [DAT_W-1:0] need
);
    localparam int SH = $clog2(UNIT_BYTES);

    logic [LEN_W:0] padded;

    // Round up by adding one unit less one byte, then drop the byte offset.
    always_comb begin
        padded = {1'b0, len} + (LEN_W + 1)'(UNIT_BYTES - 1);
        need   = DAT_W'(padded >> SH);
    end
endmodule

// File: rtl/credit_fit.sv
// Module: modulo flow-control check for one credit type.
// Passes when (limit - (consumed + need)) mod 2^W lies within half the range,
// when the type is unlimited, or when nothing is needed.
module credit_fit #(
    parameter int W = 8
) (
    input  logic [W-1:0] limit,
    input  logic [W-1:0] consumed,
    input  logic [W-1:0] need,
    input  logic         unl,
    output logic         ok
);
    localparam logic [W-1:0] HALF = W'(1) << (W - 1);

    logic [W-1:0] headroom;

    // Projected free space with wrap, then compare against half the range.
    always_comb begin
        headroom = limit - (consumed + need);
        ok       = unl || (need == '0) || (headroom <= HALF);
    end
endmodule

// File: rtl/credit_lane.sv
// Module: consumed counters and fit checks for one TLP class.
// Counters take core pulses and the block's own charges in the same cycle.
// They are held at zero while the link is down. Assumes the core pulses
// at most one credit per type per cycle.
module credit_lane #(
    parameter int HDR_W = 8,
    parameter int DAT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_up,
    input  logic [HDR_W-1:0] lim_h,
    input  logic [DAT_W-1:0] lim_d,
    input  logic             core_h,
    input  logic             core_d,
    input  logic             unl_h,
    input  logic             unl_d,
    input  logic [DAT_W-1:0] need_d,
    input  logic             commit,
    output logic             ok,
    output logic [HDR_W-1:0] cons_h,
    output logic [DAT_W-1:0] cons_d
);
    logic ok_h, ok_d;

    credit_fit #(.W(HDR_W)) u_fit_h (
        .limit(lim_h), .consumed(cons_h), .need(HDR_W'(1)),
        .unl(unl_h), .ok(ok_h)
    );

    credit_fit #(.W(DAT_W)) u_fit_d (
        .limit(lim_d), .consumed(cons_d), .need(need_d),
        .unl(unl_d), .ok(ok_d)
    );

    // Both checks must pass for this class to be granted.
    assign ok = ok_h && ok_d;

    // Accumulate core pulses plus own charges; clear on reset or link down.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_up) begin
            cons_h <= '0;
            cons_d <= '0;
        end else begin
            cons_h <= cons_h + HDR_W'(core_h) + HDR_W'(commit);
            cons_d <= cons_d + DAT_W'(core_d) + (commit ? need_d : '0);
        end
    end

    AST_DOWN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (cons_h == '0) && (cons_d == '0)); // R7

    AST_HDR_STEP_MAX2: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |=> (HDR_W'(cons_h - $past(cons_h)) <= HDR_W'(2))); // R4

    AST_HDR_BOTH_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        link_up && commit && core_h |=> (cons_h == HDR_W'($past(cons_h) + HDR_W'(2)))); // R4

    AST_UNL_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        unl_h && (unl_d || need_d == '0) |-> ok); // R6
endmodule

// File: rtl/tx_credit_gate.sv
// Module: transmit flow-control credit gate (top).
// Grants an offered TLP when its class has header and data space, charges it
// in the same cycle and reports the charge one cycle later. Assumes limits are
// stable or only grow while the link is up. The offered TLP is taken as sent
// whenever grant is high.
module tx_credit_gate
    import tx_credit_pkg::*;
#(
    parameter int HDR_W      = 8,
    parameter int DAT_W      = 12,
    parameter int LEN_W      = 13,
    parameter int UNIT_BYTES = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            link_up,
    input  logic [NUM_CLS-1:0][HDR_W-1:0]   lim_hdr,
    input  logic [NUM_CLS-1:0][DAT_W-1:0]   lim_dat,
    input  logic [2*NUM_CLS-1:0]            core_used,
    input  logic [2*NUM_CLS-1:0]            unlimited,
    input  logic                            req_valid,
    input  logic [1:0]                      req_class,
    input  logic [LEN_W-1:0]                req_len,
    input  logic                            view_sel,
    output logic                            grant,
    output logic                            upd_valid,
    output logic [1:0]                      upd_class,
    output logic [DAT_W-1:0]                upd_dat,
    output logic [NUM_CLS-1:0][HDR_W-1:0]   view_hdr,
    output logic [NUM_CLS-1:0][DAT_W-1:0]   view_dat
);
    logic [DAT_W-1:0]                need_d;
    logic [NUM_CLS-1:0]              lane_sel;
    logic [NUM_CLS-1:0]              lane_ok;
    logic [NUM_CLS-1:0]              lane_commit;
    logic [NUM_CLS-1:0][HDR_W-1:0]   cons_h;
    logic [NUM_CLS-1:0][DAT_W-1:0]   cons_d;

    credit_need #(.LEN_W(LEN_W), .DAT_W(DAT_W), .UNIT_BYTES(UNIT_BYTES)) u_need (
        .len(req_len), .need(need_d)
    );

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_lane
        localparam int HB = hdr_bit(c);
        localparam int DB = dat_bit(c);

        assign lane_sel[c]    = req_valid && (req_class == 2'(c));
        assign lane_commit[c] = grant && lane_sel[c];

        credit_lane #(.HDR_W(HDR_W), .DAT_W(DAT_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .link_up(link_up),
            .lim_h(lim_hdr[c]), .lim_d(lim_dat[c]),
            .core_h(core_used[HB]), .core_d(core_used[DB]),
            .unl_h(unlimited[HB]), .unl_d(unlimited[DB]),
            .need_d(need_d), .commit(lane_commit[c]),
            .ok(lane_ok[c]), .cons_h(cons_h[c]), .cons_d(cons_d[c])
        );

        // Credit view: consumed totals or limits, per select.
        assign view_hdr[c] = view_sel ? cons_h[c] : lim_hdr[c];
        assign view_dat[c] = view_sel ? cons_d[c] : lim_dat[c];
    end

    // Grant only with the link up and the selected class fitting.
    assign grant = link_up && |(lane_sel & lane_ok);

    // Record the charge applied this cycle for the application.
    always_ff @(posedge clk) begin
        if (!rst_n || !grant) begin
            upd_valid <= 1'b0;
            upd_class <= 2'd0;
            upd_dat   <= '0;
        end else begin
            upd_valid <= 1'b1;
            upd_class <= req_class;
            upd_dat   <= need_d;
        end
    end

    AST_GRANT_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> link_up && req_valid); // R7

    AST_NO_GRANT_CLASS3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_class == CLS_NONE) |-> !grant); // R5

    AST_UPD_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> upd_valid && (upd_class == $past(req_class))); // R9

    AST_NO_UPD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |=> !upd_valid); // R9
endmodule

// File: tb/tx_credit_gate_bench.sv
`timescale 1ns/1ps
module tx_credit_gate_bench;
    logic             clk = 1'b0;
    logic             rst_n;
    logic             link_up;
    logic [2:0][7:0]  lim_hdr;
    logic [2:0][11:0] lim_dat;
    logic [5:0]       core_used;
    logic [5:0]       unlimited;
    logic             req_valid;
    logic [1:0]       req_class;
    logic [12:0]      req_len;
    logic             view_sel;
    logic             grant;
    logic             upd_valid;
    logic [1:0]       upd_class;
    logic [11:0]      upd_dat;
    logic [2:0][7:0]  view_hdr;
    logic [2:0][11:0] view_dat;

    always #2.5 clk = ~clk;

    tx_credit_gate u_tx_credit_gate (
        .clk(clk), .rst_n(rst_n), .link_up(link_up),
        .lim_hdr(lim_hdr), .lim_dat(lim_dat),
        .core_used(core_used), .unlimited(unlimited),
        .req_valid(req_valid), .req_class(req_class), .req_len(req_len),
        .view_sel(view_sel), .grant(grant),
        .upd_valid(upd_valid), .upd_class(upd_class), .upd_dat(upd_dat),
        .view_hdr(view_hdr), .view_dat(view_dat)
    );

    // Reference state: consumed totals and the expected update record.
    int mh[3];
    int md[3];
    int e_uv, e_uc, e_ud;
    int vectors = 0;
    int errors  = 0;

    function automatic int need_of(input int len);
        return (len + 15) / 16; // R2
    endfunction

    function automatic int exp_grant();
        int c, nd, hr, dr;
        bit hok, dok;
        if (!link_up || !req_valid || req_class == 2'd3) return 0;
        c   = int'(req_class);
        nd  = need_of(int'(req_len));
        hr  = (int'(lim_hdr[c]) - (mh[c] + 1)) & 255;
        dr  = (int'(lim_dat[c]) - (md[c] + nd)) & 4095;
        hok = unlimited[5 - 2*c] || hr <= 128;              // R5 R6
        dok = nd == 0 || unlimited[4 - 2*c] || dr <= 2048;  // R2 R6
        return (hok && dok) ? 1 : 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: compare outputs mid-cycle, then advance the model at the edge.
    task automatic step();
        int g, nd;
        #1;
        g = exp_grant();
        chk("R5 grant", int'(grant), g);
        chk("R9 upd_valid", int'(upd_valid), e_uv);
        chk("R9 upd_class", int'(upd_class), e_uc);
        chk("R9 upd_dat", int'(upd_dat), e_ud);
        for (int c = 0; c < 3; c++) begin
            chk("R8 R1 R3 view_hdr", int'(view_hdr[c]), view_sel ? mh[c] : int'(lim_hdr[c]));
            chk("R8 R1 R3 view_dat", int'(view_dat[c]), view_sel ? md[c] : int'(lim_dat[c]));
        end
        nd = need_of(int'(req_len));
        @(posedge clk);
        if (!rst_n) begin // R10
            for (int c = 0; c < 3; c++) begin mh[c] = 0; md[c] = 0; end
            e_uv = 0; e_uc = 0; e_ud = 0;
        end else begin
            e_uv = g;
            e_uc = g ? int'(req_class) : 0;
            e_ud = g ? nd : 0;
            for (int c = 0; c < 3; c++) begin
                if (!link_up) begin // R7
                    mh[c] = 0; md[c] = 0;
                end else begin      // R1 R3 R4
                    mh[c] = (mh[c] + int'(core_used[5 - 2*c]) +
                             ((g != 0 && int'(req_class) == c) ? 1 : 0)) & 255;
                    md[c] = (md[c] + int'(core_used[4 - 2*c]) +
                             ((g != 0 && int'(req_class) == c) ? nd : 0)) & 4095;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic offer(input int cls, input int len);
        req_valid = 1'b1;
        req_class = 2'(cls);
        req_len   = 13'(len);
        step();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; link_up = 1'b1; view_sel = 1'b1;
        lim_hdr = '0; lim_dat = '0; unlimited = '0;
        core_used = 6'h3F; req_valid = 1'b1; req_class = 2'd0; req_len = 13'd32;
        for (int c = 0; c < 3; c++) begin mh[c] = 0; md[c] = 0; end
        e_uv = 0; e_uc = 0; e_ud = 0;
        @(negedge clk);
        repeat (3) step();                      // R10 reset holds counters clear

        // R7: link down, requests and pulses ignored
        rst_n = 1'b1; link_up = 1'b0;
        lim_hdr = {8'd50, 8'd50, 8'd50}; lim_dat = {12'd500, 12'd500, 12'd500};
        repeat (4) step();

        // R1 R2 R5: posted limits 3 headers, 10 data credits
        link_up = 1'b1; core_used = '0;
        lim_hdr = {8'd2, 8'd2, 8'd3}; lim_dat = {12'd4, 12'd4, 12'd10};
        offer(0, 64); offer(0, 64); offer(0, 64);  // third blocked on data
        offer(0, 17); offer(0, 0); offer(0, 0);    // R2 17 bytes -> 2, then header-only
        offer(1, 1); offer(1, 16); offer(1, 16);   // R2 one credit each
        offer(2, 0); offer(3, 0);                  // R5 class 3 refused
        view_sel = 1'b0; offer(2, 48); view_sel = 1'b1; // R8 limit view

        // R3 R4: core pulses alone and together with own charges
        req_valid = 1'b0;
        lim_hdr = {8'd200, 8'd200, 8'd200}; lim_dat = {12'd3000, 12'd3000, 12'd3000};
        core_used = 6'b110000; step();
        core_used = 6'b001100; step();
        core_used = 6'b000010; step();
        core_used = 6'b110000; offer(0, 32);       // R4 same counter same cycle
        core_used = 6'b000011; offer(2, 100);      // R4
        core_used = '0;

        // R6: unlimited flags bypass tiny limits
        lim_hdr = '0; lim_dat = '0;
        offer(1, 64);                              // blocked
        unlimited = 6'b001100; offer(1, 64); offer(1, 64);
        unlimited = 6'b001000; offer(1, 64); offer(1, 0); // data still limited
        unlimited = '0;

        // R5: header counter wraps past 255
        req_valid = 1'b0; lim_hdr = {8'd5, 8'd5, 8'd5};
        core_used = 6'b100000;
        repeat (300) step();
        core_used = '0;
        offer(0, 0);                               // far over limit
        lim_hdr[0] = mh[0] + 1; offer(0, 0);       // exactly fits
        offer(0, 0);                               // now one over

        // R7: link drop clears counters, then recovery
        link_up = 1'b0; offer(0, 16); step();
        link_up = 1'b1; step();

        // Mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            int k, m;
            if (i % 64 == 0) begin
                for (int c = 0; c < 3; c++) begin
                    lim_hdr[c] = 8'((mh[c] + $urandom_range(0, 20)) & 255);
                    lim_dat[c] = 12'((md[c] + $urandom_range(0, 120)) & 4095);
                end
            end
            k = $urandom_range(0, 2);
            m = $urandom_range(0, 3);
            core_used = '0;
            if (m == 1 || m == 2) core_used[5 - 2*k] = 1'b1;
            if (m == 2)           core_used[4 - 2*k] = 1'b1;
            unlimited = ($urandom_range(0, 15) == 0) ? 6'($urandom) : 6'd0;
            link_up   = ($urandom_range(0, 499) != 0);
            view_sel  = ($urandom_range(0, 7) != 0);
            req_valid = 1'($urandom);
            req_class = 2'($urandom);
            req_len   = 13'($urandom_range(0, 600));
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule